// File: doc/BRIEF.md
# Audio Enhancer Command Port (I2C Slave)

This block is the host-facing command port of a voice enhancement datapath. A host controller sends it short I2C write frames made of a slave address, a one-byte command and, for some commands, one data byte. The port decodes these frames and holds the resulting configuration: DSP on/off, enhancement or equalizer mode, enhancement strength, four equalizer band gains, ten enhancement filter gains and a noise-gate threshold. These values leave the block as plain register outputs for the audio datapath.

Both bus lines are sampled with the system clock. Each line passes through a three-flop synchronizer and then a three-sample majority vote, so pulses of one clock period are rejected. Start and stop conditions and bit edges are detected on the filtered lines. A query command picks one byte: either the packed status or one band's tone code. The host then fetches that byte with a one-byte read frame at the companion read address.

Top module: `cmd_i2c_slave`

## Requirements
- R1: After reset the DSP is off (dspOff=1), eqMode=0, enhLevel=01 (80%), every band code is 0x0C (0 dB), every filter gain code is 0xC, noiseThr=0x1F, and the read selector points at the status byte.
- R2: The 7-bit slave address is binary 100000 followed by addrSel. The R/W bit is 0 for a write and 1 for a read, so with addrSel low the address bytes are 0x80 and 0x81. A matching address byte is ACKed by pulling SDA low. Any other address is not ACKed, and the rest of that frame has no effect.
- R3: Command 0x01 sets dspOff=1. Command 0x02 sets dspOff=0 and eqMode=0. Command 0x03 sets dspOff=0 and eqMode=1.
- R4: Commands 0x04 to 0x08 load the band codes (code = 12 + dB) for bands 1 to 4 as follows. 0x04: 0,0,0,0 dB. 0x05: +3,-1,-1,+1 dB. 0x06: +3,0,0,+3 dB. 0x07: +5,0,0,0 dB. 0x08: +5,0,0,+1 dB. Band 1 sits in bandGains[4:0] and band n in bits [5n-1:5n-5].
- R5: Command 0x0A takes a data byte. Bits [7:5] select band 1 to 4 (000 to 011) and bits [4:0] give the gain code, where 0x00 = -12 dB, 0x0C = 0 dB and 0x18 = +12 dB.
- R6: Command 0x09 takes a data byte of 0x00, 0x01 or 0x02, which sets enhLevel to 100%, 80% or 60% (codes 00, 01, 10).
- R7: Command 0x0B takes a data byte. Bits [7:4] give the filter index 0 to 9 and bits [3:0] the code 0x0 to 0xC. Filter k sits in filtGains[4k+3:4k].
- R8: Command 0x0D takes any data byte and loads it into noiseThr.
- R9: A data byte that is out of range is ACKed but leaves every register unchanged. Out of range means a level above 0x02, a band field above 011, a gain code above 0x18, a filter index above 9, a filter code above 0xC, or a query code outside 0x01 to 0x05.
- R10: A command byte outside 0x01 to 0x0B, 0x0D and 0x0E is NACKed and has no effect. A byte sent after a command that takes no data is also NACKed.
- R11: Command 0x0E with data 0x01 selects the status byte {4'b0, enhLevel, eqMode, dspOff}. Data 0x02 to 0x05 select the code of band 1 to 4, returned zero-extended. A read frame returns the selected byte MSB first, and the selection persists.
- R12: A pulse of a single clock period on SCL or SDA is ignored.
- R13: A stop condition before the data byte of a data command is complete leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| addrSel | input | 1 | Address-select pin, LSB of the 7-bit address |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 = pull SDA low |
| dspOff | output | 1 | 1 = datapath bypassed |
| eqMode | output | 1 | 0 = enhancement, 1 = equalizer |
| enhLevel | output | 2 | Enhancement strength code |
| bandGains | output | 20 | Four 5-bit band gain codes |
| filtGains | output | 40 | Ten 4-bit filter gain codes |
| noiseThr | output | 8 | Noise-gate threshold |

## Verification
The assertions check on every cycle that the level code never reaches 11, that band codes stay at or below 0x18 and filter codes at or below 0xC, and that the DSP-off flag and noise threshold change only right after a command or data strobe. They also check that SDA is driven only in an acknowledge or read slot and changes only while the filtered SCL is low. Only the bench scenarios show the bit-level content of the decode: the preset values, address matching against the pin, ACK versus NACK per byte, the selected readback byte, glitch rejection and abort by stop. The bench checks these against a reference model across directed and random frames.

// File: rtl/vipcmd_pkg.sv
package vipcmd_pkg;
  localparam int BANDS    = 4;
  localparam int GAIN_W   = 5;
  localparam int FILTS    = 10;
  localparam int FGAIN_W  = 4;
  localparam int GAIN_ZERO = 12;
  localparam int GAIN_MAX  = 24;
  localparam int FGAIN_MAX = 12;
  localparam int BIDX_W   = $clog2(BANDS);
  localparam int FIDX_W   = $clog2(FILTS);

  localparam logic [7:0] CMD_BYPASS = 8'h01;
  localparam logic [7:0] CMD_ENH    = 8'h02;
  localparam logic [7:0] CMD_EQ     = 8'h03;
  localparam logic [7:0] CMD_FLAT   = 8'h04;
  localparam logic [7:0] CMD_PRE4   = 8'h08;
  localparam logic [7:0] CMD_LEVEL  = 8'h09;
  localparam logic [7:0] CMD_TONE   = 8'h0A;
  localparam logic [7:0] CMD_FILT   = 8'h0B;
  localparam logic [7:0] CMD_NOISE  = 8'h0D;
  localparam logic [7:0] CMD_QUERY  = 8'h0E;

  typedef struct packed {
    logic       cmdStb;
    logic       dataStb;
    logic [7:0] rxByte;
  } stb_t;

  function automatic logic cmdKnown(input logic [7:0] c);
    return (c >= CMD_BYPASS && c <= CMD_FILT) || c == CMD_NOISE || c == CMD_QUERY;
  endfunction

  function automatic logic cmdTakesData(input logic [7:0] c);
    return c == CMD_LEVEL || c == CMD_TONE || c == CMD_FILT ||
           c == CMD_NOISE || c == CMD_QUERY;
  endfunction

  // Gain code for one band under one of the tone presets
  function automatic logic [GAIN_W-1:0] presetCode(input logic [7:0] c, input int band);
    int db;
    db = 0;
    case (c)
      8'h05: db = (band == 0) ? 3 : (band == 3) ? 1 : -1;
      8'h06: db = (band == 0 || band == 3) ? 3 : 0;
      8'h07: db = (band == 0) ? 5 : 0;
      8'h08: db = (band == 0) ? 5 : (band == 3) ? 1 : 0;
      default: db = 0;
    endcase
    return GAIN_W'(GAIN_ZERO + db);
  endfunction
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int LINES  = 2,
  parameter int SYNC_N = 3,
  parameter int WIN    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);
  genvar l;
  generate
    for (l = 0; l < LINES; l++) begin : g_line
      logic [SYNC_N-1:0] syncQ;
      logic [WIN-1:0]    histQ;
      logic              cleanQ;
      logic              majority;

      always_comb begin
        int ones;
        ones = 0;
        for (int k = 0; k < WIN; k++) ones += int'(histQ[k]);
        majority = (ones > WIN / 2);
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncQ  <= '1;
          histQ  <= '1;
          cleanQ <= 1'b1;
        end else begin
          syncQ  <= {syncQ[SYNC_N-2:0], rawIn[l]};
          histQ  <= {histQ[WIN-2:0], syncQ[SYNC_N-1]};
          cleanQ <= majority;
        end
      end
      assign cleanOut[l] = cleanQ;
    end
  endgenerate
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import vipcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] readByte,
  output logic       sdaOe,
  output stb_t       stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_ACK, ST_READ, ST_RACK, ST_SKIP
  } st_e;

  st_e        state, nextSt;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startEv, stopEv;

  assign sclRise = sclF && !sclPrev;
  assign sclFall = !sclF && sclPrev;
  assign startEv = sclF && sclPrev && sdaPrev && !sdaF;
  assign stopEv  = sclF && sclPrev && !sdaPrev && sdaF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nextSt  <= ST_IDLE;
      bitCnt  <= '0;
      shReg   <= '0;
      txReg   <= '0;
      sdaOe   <= 1'b0;
      stb     <= '0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev     <= sclF;
      sdaPrev     <= sdaF;
      stb.cmdStb  <= 1'b0;
      stb.dataStb <= 1'b0;
      if (startEv) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopEv) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              state  <= ST_SKIP;
              if (state == ST_ADDR) begin
                if (shReg[7:1] == {6'b100000, addrSel}) begin
                  sdaOe  <= 1'b1;
                  state  <= ST_ACK;
                  nextSt <= shReg[0] ? ST_READ : ST_CMD;
                end
              end else if (state == ST_CMD) begin
                if (cmdKnown(shReg)) begin
                  sdaOe      <= 1'b1;
                  state      <= ST_ACK;
                  stb.cmdStb <= 1'b1;
                  stb.rxByte <= shReg;
                  nextSt     <= cmdTakesData(shReg) ? ST_DATA : ST_SKIP;
                end
              end else begin
                sdaOe       <= 1'b1;
                state       <= ST_ACK;
                stb.dataStb <= 1'b1;
                stb.rxByte  <= shReg;
                nextSt      <= ST_SKIP;
              end
            end
          end
          ST_ACK: if (sclFall) begin
            state  <= nextSt;
            bitCnt <= '0;
            if (nextSt == ST_READ) begin
              txReg <= readByte;
              sdaOe <= ~readByte[7];
            end else begin
              sdaOe <= 1'b0;
            end
          end
          ST_READ: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= ST_RACK;
              end else begin
                txReg <= {txReg[6:0], 1'b0};
                sdaOe <= ~txReg[6];
              end
            end
          end
          ST_RACK: if (sclRise) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  // R2
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclF);
  // R10
  oe_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state == ST_ACK || state == ST_READ));
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import vipcmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  stb_t                       stb,
  output logic                       dspOff,
  output logic                       eqMode,
  output logic [1:0]                 enhLevel,
  output logic [BANDS*GAIN_W-1:0]    bandGains,
  output logic [FILTS*FGAIN_W-1:0]   filtGains,
  output logic [7:0]                 noiseThr,
  output logic [7:0]                 readByte
);
  logic [GAIN_W-1:0]  bandGain [BANDS];
  logic [FGAIN_W-1:0] filtGain [FILTS];
  logic [7:0]         lastCmd;
  logic [2:0]         readSel;
  logic [BIDX_W-1:0]  rdIdx;
  logic [7:0]         rx;

  assign rx = stb.rxByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dspOff   <= 1'b1;
      eqMode   <= 1'b0;
      enhLevel <= 2'b01;
      noiseThr <= 8'h1F;
      readSel  <= 3'd1;
      lastCmd  <= '0;
      for (int b = 0; b < BANDS; b++) bandGain[b] <= GAIN_W'(GAIN_ZERO);
      for (int f = 0; f < FILTS; f++) filtGain[f] <= FGAIN_W'(FGAIN_MAX);
    end else if (stb.cmdStb) begin
      lastCmd <= rx;
      case (rx)
        CMD_BYPASS: dspOff <= 1'b1;
        CMD_ENH:    begin dspOff <= 1'b0; eqMode <= 1'b0; end
        CMD_EQ:     begin dspOff <= 1'b0; eqMode <= 1'b1; end
        default:
          if (rx >= CMD_FLAT && rx <= CMD_PRE4)
            for (int b = 0; b < BANDS; b++) bandGain[b] <= presetCode(rx, b);
      endcase
    end else if (stb.dataStb) begin
      case (lastCmd)
        CMD_LEVEL: if (rx <= 8'h02) enhLevel <= rx[1:0];
        CMD_TONE:
          if (int'(rx[7:5]) < BANDS && int'(rx[4:0]) <= GAIN_MAX)
            bandGain[rx[5+:BIDX_W]] <= rx[4:0];
        CMD_FILT:
          if (int'(rx[7:4]) < FILTS && int'(rx[3:0]) <= FGAIN_MAX)
            filtGain[rx[4+:FIDX_W]] <= rx[3:0];
        CMD_NOISE: noiseThr <= rx;
        CMD_QUERY:
          if (rx >= 8'h01 && int'(rx) <= BANDS + 1) readSel <= rx[2:0];
        default: ;
      endcase
    end
  end

  assign rdIdx    = BIDX_W'(readSel - 3'd2);
  assign readByte = (readSel == 3'd1) ? {4'b0, enhLevel, eqMode, dspOff}
                                      : {{(8-GAIN_W){1'b0}}, bandGain[rdIdx]};

  genvar g;
  generate
    for (g = 0; g < BANDS; g++) begin : g_band
      assign bandGains[g*GAIN_W +: GAIN_W] = bandGain[g];
      // R5
      gain_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        int'(bandGain[g]) <= GAIN_MAX);
    end
    for (g = 0; g < FILTS; g++) begin : g_filt
      assign filtGains[g*FGAIN_W +: FGAIN_W] = filtGain[g];
      // R7
      filt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        int'(filtGain[g]) <= FGAIN_MAX);
    end
  endgenerate

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    enhLevel != 2'b11);
  // R3
  bypass_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dspOff) |-> $past(stb.cmdStb));
  // R8
  noise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(noiseThr) |-> $past(stb.dataStb));
endmodule

// File: rtl/cmd_i2c_slave.sv
module cmd_i2c_slave
  import vipcmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     addrSel,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaOe,
  output logic                     dspOff,
  output logic                     eqMode,
  output logic [1:0]               enhLevel,
  output logic [BANDS*GAIN_W-1:0]  bandGains,
  output logic [FILTS*FGAIN_W-1:0] filtGains,
  output logic [7:0]               noiseThr
);
  logic [1:0] cleanLines;
  logic [7:0] readByte;
  stb_t       stb;

  line_deglitch #(.LINES(2), .SYNC_N(3), .WIN(3)) u_deglitch (
    .clk(clk), .rstN(rstN), .rawIn({sdaIn, sclIn}), .cleanOut(cleanLines));

  bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel),
    .sclF(cleanLines[0]), .sdaF(cleanLines[1]),
    .readByte(readByte), .sdaOe(sdaOe), .stb(stb));

  cmd_regfile u_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dspOff(dspOff), .eqMode(eqMode), .enhLevel(enhLevel),
    .bandGains(bandGains), .filtGains(filtGains), .noiseThr(noiseThr),
    .readByte(readByte));
endmodule

// File: tb/tb_cmd_i2c_slave.sv
module tb_cmd_i2c_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrSel = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, dspOff, eqMode;
  logic [1:0] enhLevel;
  logic [19:0] bandGains;
  logic [39:0] filtGains;
  logic [7:0] noiseThr;
  logic sdaBus;

  int checks = 0, errors = 0;
  bit finished = 0;

  int eDsp, eEq, eLvl, eNoise, eSel;
  int eBand [4];
  int eFilt [10];

  assign sdaBus = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  cmd_i2c_slave dut (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .dspOff(dspOff), .eqMode(eqMode), .enhLevel(enhLevel),
    .bandGains(bandGains), .filtGains(filtGains), .noiseThr(noiseThr));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1; sclM = 1; tick(H); sdaM = 0; tick(H); sclM = 0; tick(H);
  endtask

  task automatic busStop;
    sdaM = 0; tick(H); sclM = 1; tick(H); sdaM = 1; tick(H);
  endtask

  task automatic sendBit(input bit b, input bit glitch);
    sdaM = b; tick(H/2);
    if (glitch) begin sclM = 1; tick(1); sclM = 0; end
    tick(H/2); sclM = 1; tick(H); sclM = 0; tick(3);
  endtask

  task automatic recvBit(output bit b);
    sdaM = 1; tick(H); sclM = 1; tick(H/2); b = sdaBus; tick(H/2); sclM = 0; tick(3);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) sendBit(v[i], glitch && i == 3);
    recvBit(a);
    ack = !a;
  endtask

  function automatic logic [7:0] addrByte(input bit rd);
    return {6'b100000, addrSel, rd};
  endfunction

  function automatic bit expKnown(input logic [7:0] c);
    return (c >= 8'h01 && c <= 8'h0B) || c == 8'h0D || c == 8'h0E;
  endfunction

  function automatic bit expData(input logic [7:0] c);
    return c == 8'h09 || c == 8'h0A || c == 8'h0B || c == 8'h0D || c == 8'h0E;
  endfunction

  function automatic int presetDb(input logic [7:0] c, input int b);
    int t [4];
    case (c)
      8'h05: t = '{3, -1, -1, 1};
      8'h06: t = '{3, 0, 0, 3};
      8'h07: t = '{5, 0, 0, 0};
      8'h08: t = '{5, 0, 0, 1};
      default: t = '{0, 0, 0, 0};
    endcase
    return t[b];
  endfunction

  function automatic logic [7:0] expRead();
    if (eSel == 1) return 8'(eLvl * 4 + eEq * 2 + eDsp);
    return 8'(eBand[eSel-2]);
  endfunction

  task automatic modelReset;
    eDsp = 1; eEq = 0; eLvl = 1; eNoise = 8'h1F; eSel = 1;
    foreach (eBand[b]) eBand[b] = 12;
    foreach (eFilt[f]) eFilt[f] = 12;
  endtask

  task automatic modelCmd(input logic [7:0] c);
    if (c == 8'h01) eDsp = 1;
    if (c == 8'h02) begin eDsp = 0; eEq = 0; end
    if (c == 8'h03) begin eDsp = 0; eEq = 1; end
    if (c >= 8'h04 && c <= 8'h08) foreach (eBand[b]) eBand[b] = 12 + presetDb(c, b);
  endtask

  task automatic modelData(input logic [7:0] c, input logic [7:0] d);
    case (c)
      8'h09: if (d <= 2) eLvl = d;
      8'h0A: if (d[7:5] <= 3 && d[4:0] <= 24) eBand[d[7:5]] = d[4:0];
      8'h0B: if (d[7:4] <= 9 && d[3:0] <= 12) eFilt[d[7:4]] = d[3:0];
      8'h0D: eNoise = d;
      8'h0E: if (d >= 1 && d <= 5) eSel = d;
      default: ;
    endcase
  endtask

  task automatic checkRegs(input string req);
    logic [19:0] bx;
    logic [39:0] fx;
    for (int b = 0; b < 4; b++) bx[b*5 +: 5] = 5'(eBand[b]);
    for (int f = 0; f < 10; f++) fx[f*4 +: 4] = 4'(eFilt[f]);
    check(dspOff == 1'(eDsp) && eqMode == 1'(eEq), req, "mode",
          {dspOff, eqMode}, {1'(eDsp), 1'(eEq)});
    check(enhLevel == 2'(eLvl), req, "level", enhLevel, eLvl);
    check(bandGains == bx, req, "bands", bandGains, bx);
    check(filtGains == fx, req, "filters", filtGains, fx);
    check(noiseThr == 8'(eNoise), req, "noise", noiseThr, eNoise);
  endtask

  // Full write frame; the model follows only what the slave should accept
  task automatic writeCmd(input logic [7:0] c, input logic [7:0] d, input bit glitch,
                          input string req);
    bit aA, aC, aD;
    busStart;
    sendByte(addrByte(0), 0, aA);
    check(aA, req, "addr ack", aA, 1);
    sendByte(c, 0, aC);
    check(aC == expKnown(c), req, "cmd ack", aC, expKnown(c));
    if (aC) modelCmd(c);
    if (aC && expData(c)) begin
      sendByte(d, glitch, aD);
      check(aD, req, "data ack", aD, 1);
      modelData(c, d);
    end
    busStop;
  endtask

  task automatic readBack(input string req);
    bit aA, b;
    logic [7:0] v;
    busStart;
    sendByte(addrByte(1), 0, aA);
    check(aA, req, "read addr ack", aA, 1);
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(1, 0);
    busStop;
    check(v == expRead(), req, "read byte", v, expRead());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'h1D0C5EED));
    modelReset;
    tick(12);
    rstN = 1;
    tick(12);
    // R1 defaults
    checkRegs("R1");
    readBack("R1");

    // R2 wrong address and wrong pin level are ignored
    busStart; sendByte(8'h84, 0, ack); busStop;
    check(!ack, "R2", "foreign addr nack", ack, 0);
    addrSel = 1;
    busStart; sendByte(8'h80, 0, ack);
    check(!ack, "R2", "pin mismatch nack", ack, 0);
    sendByte(8'h02, 0, ack); busStop;
    checkRegs("R2");
    writeCmd(8'h02, 8'h00, 0, "R2");
    checkRegs("R2");
    addrSel = 0;

    // R3 mode commands
    writeCmd(8'h03, 8'h00, 0, "R3"); checkRegs("R3");
    writeCmd(8'h01, 8'h00, 0, "R3"); checkRegs("R3");
    writeCmd(8'h02, 8'h00, 0, "R3"); checkRegs("R3");

    // R4 presets
    for (int c = 5; c <= 8; c++) begin
      writeCmd(8'(c), 8'h00, 0, "R4"); checkRegs("R4");
    end
    writeCmd(8'h04, 8'h00, 0, "R4"); checkRegs("R4");

    // R5 tone extremes
    writeCmd(8'h0A, 8'h58, 0, "R5"); checkRegs("R5");
    writeCmd(8'h0A, 8'h00, 0, "R5"); checkRegs("R5");
    writeCmd(8'h0A, 8'h6C, 0, "R5"); checkRegs("R5");

    // R6 level and R9 out-of-range level
    writeCmd(8'h09, 8'h02, 0, "R6"); checkRegs("R6");
    writeCmd(8'h09, 8'h03, 0, "R9"); checkRegs("R9");

    // R7 filter gain, R9 out-of-range code, index and band
    writeCmd(8'h0B, 8'h9A, 0, "R7"); checkRegs("R7");
    writeCmd(8'h0B, 8'h30, 0, "R7"); checkRegs("R7");
    writeCmd(8'h0B, 8'h3D, 0, "R9"); checkRegs("R9");
    writeCmd(8'h0B, 8'hA0, 0, "R9"); checkRegs("R9");
    writeCmd(8'h0A, 8'h19, 0, "R9"); checkRegs("R9");
    writeCmd(8'h0A, 8'h85, 0, "R9"); checkRegs("R9");

    // R8 noise threshold, with an SCL glitch inside the data byte (R12)
    writeCmd(8'h0D, 8'h00, 1, "R8"); checkRegs("R8");
    writeCmd(8'h0D, 8'hA5, 1, "R12"); checkRegs("R12");

    // R10 unknown commands and a surplus byte
    writeCmd(8'h0C, 8'h11, 0, "R10");
    writeCmd(8'h00, 8'h11, 0, "R10");
    writeCmd(8'hFF, 8'h11, 0, "R10");
    checkRegs("R10");
    begin
      bit aA, aC, aX;
      busStart;
      sendByte(addrByte(0), 0, aA);
      sendByte(8'h03, 0, aC); modelCmd(8'h03);
      sendByte(8'h09, 0, aX);
      busStop;
      check(!aX, "R10", "surplus byte nack", aX, 0);
      checkRegs("R10");
    end

    // R11 query selection and status readback
    writeCmd(8'h0E, 8'h03, 0, "R11"); readBack("R11"); readBack("R11");
    writeCmd(8'h0E, 8'h05, 0, "R11"); readBack("R11");
    writeCmd(8'h0E, 8'h07, 0, "R9");  readBack("R9");
    writeCmd(8'h0E, 8'h01, 0, "R11"); readBack("R11");

    // R13 stop in the middle of a data byte
    begin
      bit aA, aC;
      busStart;
      sendByte(addrByte(0), 0, aA);
      sendByte(8'h0D, 0, aC);
      for (int i = 0; i < 4; i++) sendBit(1'(i), 0);
      busStop;
      checkRegs("R13");
    end

    // Random frames mixed with readbacks
    for (int it = 0; it < 70; it++) begin
      int r;
      logic [7:0] c, d;
      r = int'($urandom % 18);
      c = (r < 15) ? 8'(r) : (r == 15) ? 8'hFF : 8'h0C;
      d = 8'($urandom);
      if (c == 8'h0A) d = {3'($urandom % 5), 5'($urandom % 27)};
      if (c == 8'h0E) d = 8'($urandom % 7);
      writeCmd(c, d, it % 5 == 0, "R11");
      checkRegs("R9");
      if (c == 8'h0E) readBack("R11");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule